// File: doc/BRIEF.md
# Add-Only Programmable Memory Write Controller

This block models the programming path of a small one-time-programmable byte memory. A program request brings a byte address and a data byte. The controller decides whether the target page may still be written. If it may, the new data is merged into the stored byte so that bits can only move from the erased value 1 to the programmed value 0. Every request gets a one-cycle accept or reject pulse. A rejected request changes nothing in the array.

The address space is split into equal pages. The lowest pages are locked for good and come out of reset holding a fixed image. Every other page has one protect bit in a small status register. Its erased value 1 leaves the page writable, and programming it to 0 locks the page. A separate status request sets protect bits with the same add-only rule, so a lock can never be undone. A registered read port returns any stored byte. The protect bits are visible on their own output.

Top module: `aom_ctrl`

## Requirements
- R1: A synchronous active-high reset sets every byte at or above address 20h to FFh and all three protect bits (`prot_q`) to 1. Byte i of the locked page (addresses 00h to 1Fh) is set to (37*i + 11) mod 256.
- R2: An accepted program request stores the old byte ANDed with `prog_data`. A requested bit of 1 over a stored 0 is ignored, so that bit stays 0.
- R3: Any program request with address bits [6:5] = 0 (addresses 00h to 1Fh) is rejected, and the addressed byte keeps its value.
- R4: A program request to page p (address bits [6:5] = p, p = 1 to 3) is accepted while `prot_q[p-1]` is 1. It is rejected once that bit is 0, and the byte then keeps its value.
- R5: A status request sets `prot_q` to `prot_q & stat_data` on the next clock edge and gives a one-cycle `stat_ok` pulse. A protect bit at 0 never returns to 1.
- R6: Each program request produces exactly one of `prog_ok` or `prog_rej`, high for one cycle after the request edge. Both are low when there is no request.
- R7: `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is presented.
- R8: When a program request and a status request arrive in the same cycle, the program decision uses the protect bits as they were before that status update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | Program request strobe |
| prog_addr | input | 7 | Byte address of the program request |
| prog_data | input | 8 | Data to merge into the addressed byte |
| stat_req | input | 1 | Status (protect bit) request strobe |
| stat_data | input | 3 | Protect bit values to AND into the status register |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Registered read data |
| prot_q | output | 3 | Current protect bits, bit p-1 guards page p |
| prog_ok | output | 1 | Program request accepted pulse |
| prog_rej | output | 1 | Program request rejected pulse |
| stat_ok | output | 1 | Status request done pulse |

## Verification
The hardest case to reach is a program request and a status lock to the same page in a single cycle. The write must still be accepted, and only the next request may be rejected. The bench drives both strobes in one cycle and then sends a follow-up write to the same page. It also shows that a rejected or ignored write left the byte untouched. To do this it reads the byte back through the read port after every reject and after every write that tries to turn a 0 back into a 1.

// File: rtl/aom_pkg.sv
package aom_pkg;

   // Reset image of the locked region: byte i = (37*i + seed), truncated by the caller.
   function automatic logic [31:0] seed_byte(input int idx, input int seed);
      logic [31:0] v;
      v = 32'(idx) * 32'd37 + 32'(seed);
      return v & 32'h0000_00FF;
   endfunction

   typedef struct packed {
      logic ok;
      logic rej;
   } decision_t;

endpackage

// File: rtl/aom_guard.sv
module aom_guard #(
   parameter int ADDR_W       = 7,
   parameter int PAGE_W       = 5,
   parameter int LOCKED_PAGES = 1,
   localparam int NPAGES      = 1 << (ADDR_W - PAGE_W),
   localparam int NPROT       = NPAGES - LOCKED_PAGES
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPROT-1:0]  prot,
   output logic              allow
);
   localparam int PG_W = ADDR_W - PAGE_W;

   logic [NPAGES-1:0] page_open;
   logic [PG_W-1:0]   page;

   assign page = addr[ADDR_W-1:PAGE_W];

   for (genvar p = 0; p < NPAGES; p++) begin : g_page
      if (p < LOCKED_PAGES) begin : g_fixed
         assign page_open[p] = 1'b0;
      end else begin : g_prot
         assign page_open[p] = prot[p-LOCKED_PAGES];
      end
   end

   assign allow = page_open[page];

   // R3: the permanently locked pages are never writable
   always_comb begin
      if (32'(page) < LOCKED_PAGES)
         p_locked_never_r3: assert (!allow);
   end

endmodule

// File: rtl/aom_status.sv
module aom_status #(
   parameter int NPROT = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic [NPROT-1:0] data,
   output logic [NPROT-1:0] prot,
   output logic             done
);

   always_ff @(posedge clk) begin
      if (rst) begin
         prot <= '1;
         done <= 1'b0;
      end else begin
         done <= req;
         if (req)
            prot <= prot & data;
      end
   end

   // R5: a programmed protect bit stays programmed
   p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      ((prot & ~$past(prot)) == '0));

   // R5: one completion pulse per request
   p_done_follows_r5: assert property (@(posedge clk) disable iff (rst)
      req |=> done);

endmodule

// File: rtl/aom_array.sv
module aom_array #(
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 8,
   parameter int LOCKED_BYTES = 32,
   parameter int SEED         = 11,
   localparam int DEPTH       = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   function automatic logic [DATA_W-1:0] reset_val(input int idx);
      logic [31:0] w;
      w = aom_pkg::seed_byte(idx, SEED);
      if (idx < LOCKED_BYTES)
         return w[DATA_W-1:0];
      return '1;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= reset_val(i);
         rd_data <= '1;
      end else begin
         if (wr_en)
            mem[wr_addr] <= mem[wr_addr] & wr_data;
         rd_data <= mem[rd_addr];
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_chk
      // R2: stored bits only ever move from 1 to 0
      p_addonly_r2: assert property (@(posedge clk) disable iff (rst)
         ((mem[i] & ~$past(mem[i])) == '0));
   end

endmodule

// File: rtl/aom_ctrl.sv
module aom_ctrl #(
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 8,
   parameter int PAGE_W       = 5,
   parameter int LOCKED_PAGES = 1,
   parameter int SEED         = 11,
   localparam int NPAGES      = 1 << (ADDR_W - PAGE_W),
   localparam int NPROT       = NPAGES - LOCKED_PAGES,
   localparam int LOCKED_BYTES = LOCKED_PAGES << PAGE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              prog_req,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              stat_req,
   input  logic [NPROT-1:0]  stat_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NPROT-1:0]  prot_q,
   output logic              prog_ok,
   output logic              prog_rej,
   output logic              stat_ok
);

   if (PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must be smaller than ADDR_W");
   end
   if (LOCKED_PAGES >= NPAGES) begin : g_bad_lock
      $error("at least one lockable page is required");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must be 1..32");
   end

   logic              allow;
   logic              wr_en;
   aom_pkg::decision_t dec;

   aom_guard #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOCKED_PAGES(LOCKED_PAGES)
   ) u_guard (
      .addr(prog_addr), .prot(prot_q), .allow(allow)
   );

   aom_status #(.NPROT(NPROT)) u_status (
      .clk(clk), .rst(rst), .req(stat_req), .data(stat_data),
      .prot(prot_q), .done(stat_ok)
   );

   assign wr_en = prog_req & allow;

   aom_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCKED_BYTES(LOCKED_BYTES), .SEED(SEED)
   ) u_array (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(prog_addr),
      .wr_data(prog_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dec <= '0;
      end else begin
         dec.ok  <= prog_req & allow;
         dec.rej <= prog_req & ~allow;
      end
   end

   assign prog_ok  = dec.ok;
   assign prog_rej = dec.rej;

   // R6: accept and reject never together, and no pulse without a request
   p_one_answer_r6: assert property (@(posedge clk) disable iff (rst)
      !(prog_ok && prog_rej));
   p_req_answered_r6: assert property (@(posedge clk) disable iff (rst)
      prog_req |=> (prog_ok || prog_rej));
   p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
      !prog_req |=> !(prog_ok || prog_rej));
   // R4: a cleared protect bit makes a later write to its page fail
   p_locked_rejects_r4: assert property (@(posedge clk) disable iff (rst)
      (prog_req && (32'(prog_addr[ADDR_W-1:PAGE_W]) >= LOCKED_PAGES) &&
       !prot_q[32'(prog_addr[ADDR_W-1:PAGE_W]) - LOCKED_PAGES]) |=> prog_rej);

endmodule

// File: tb/tb_aom_ctrl.sv
module tb_aom_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       prog_req = 1'b0;
   logic [6:0] prog_addr = '0;
   logic [7:0] prog_data = '0;
   logic       stat_req = 1'b0;
   logic [2:0] stat_data = '1;
   logic [6:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [2:0] prot_q;
   logic       prog_ok, prog_rej, stat_ok;

   int checks = 0;
   int errors = 0;
   logic [2:0] exp_q[$];
   logic [7:0] mdl [128];
   logic [2:0] mprot;
   logic       mon_on = 1'b0;

   always #5 clk = ~clk;

   aom_ctrl dut (
      .clk(clk), .rst(rst), .prog_req(prog_req), .prog_addr(prog_addr),
      .prog_data(prog_data), .stat_req(stat_req), .stat_data(stat_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .prot_q(prot_q),
      .prog_ok(prog_ok), .prog_rej(prog_rej), .stat_ok(stat_ok)
   );

   // Monitor: compare the pulse outputs with the scoreboard every cycle (R6)
   always @(negedge clk) begin
      if (mon_on) begin
         logic [2:0] e;
         logic [2:0] a;
         a = {prog_ok, prog_rej, stat_ok};
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL R6 pulses {ok,rej,stat}: got %b expected %b", a, e);
            end
         end else if (a !== 3'b000) begin
            checks++;
            errors++;
            $display("FAIL R6 idle pulses: got %b expected 000", a);
         end
      end
   end

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: one request cycle, scoreboard and model update
   task automatic request(input logic pr, input logic [6:0] a, input logic [7:0] d,
                          input logic sr, input logic [2:0] sd);
      logic ok;
      @(negedge clk);
      prog_req = pr; prog_addr = a; prog_data = d;
      stat_req = sr; stat_data = sd;
      ok = pr && (a[6:5] != 2'd0) && mprot[a[6:5] - 2'd1];
      @(posedge clk);
      #1;
      exp_q.push_back({ok, pr & ~ok, sr});
      if (ok) mdl[a] = mdl[a] & d;
      if (sr) mprot = mprot & sd;
      @(negedge clk);
      prog_req = 1'b0; stat_req = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [6:0] a);
      @(negedge clk);
      rd_addr = a;
      @(posedge clk);
      @(negedge clk);
      check8(tag, rd_data, mdl[a]);
   endtask

   task automatic prot_chk(input string tag);
      check8(tag, {5'd0, prot_q}, {5'd0, mprot});
   endtask

   initial begin
      for (int i = 0; i < 128; i++)
         mdl[i] = (i < 32) ? 8'((37 * i + 11) % 256) : 8'hFF;
      mprot = 3'b111;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      mon_on = 1'b1;

      // R1: reset state
      prot_chk("R1 protect bits after reset");
      read_chk("R1 locked byte 00", 7'h00);
      read_chk("R1 locked byte 1F", 7'h1F);
      read_chk("R1 erased byte 20", 7'h20);
      read_chk("R1 erased byte 7F", 7'h7F);

      // R3: locked page rejects and keeps contents
      request(1'b1, 7'h05, 8'h00, 1'b0, 3'b111);
      read_chk("R3 byte 05 unchanged", 7'h05);
      request(1'b1, 7'h1F, 8'h00, 1'b0, 3'b111);
      read_chk("R3 byte 1F unchanged", 7'h1F);

      // R2: AND merge, ones never restored
      request(1'b1, 7'h20, 8'hA5, 1'b0, 3'b111);
      read_chk("R2 byte 20 first write", 7'h20);
      request(1'b1, 7'h20, 8'h5A, 1'b0, 3'b111);
      read_chk("R2 byte 20 merged to 00", 7'h20);
      request(1'b1, 7'h7F, 8'h3C, 1'b0, 3'b111);
      request(1'b1, 7'h7F, 8'hFF, 1'b0, 3'b111);
      read_chk("R2 byte 7F ones ignored", 7'h7F);
      request(1'b1, 7'h40, 8'hF0, 1'b0, 3'b111);
      request(1'b1, 7'h40, 8'h3F, 1'b0, 3'b111);
      read_chk("R2 byte 40 merged to 30", 7'h40);

      // R5 and R4: lock page 1, then writes there fail
      request(1'b0, 7'h00, 8'h00, 1'b1, 3'b110);
      prot_chk("R5 page 1 locked");
      request(1'b1, 7'h21, 8'h00, 1'b0, 3'b111);
      read_chk("R4 byte 21 unchanged after reject", 7'h21);
      request(1'b0, 7'h00, 8'h00, 1'b1, 3'b111);
      prot_chk("R5 protect bit not restored");
      request(1'b1, 7'h60, 8'h81, 1'b0, 3'b111);
      read_chk("R4 open page 3 accepts", 7'h60);

      // R8: program and lock of the same page in one cycle
      request(1'b1, 7'h41, 8'h12, 1'b1, 3'b101);
      read_chk("R8 write before lock kept", 7'h41);
      prot_chk("R8 page 2 locked");
      request(1'b1, 7'h42, 8'h00, 1'b0, 3'b111);
      read_chk("R4 byte 42 unchanged", 7'h42);

      // R7: read latency with back-to-back addresses
      @(negedge clk);
      rd_addr = 7'h00;
      @(posedge clk);
      @(negedge clk);
      rd_addr = 7'h60;
      check8("R7 first of back-to-back", rd_data, mdl[7'h00]);
      @(posedge clk);
      @(negedge clk);
      check8("R7 second of back-to-back", rd_data, mdl[7'h60]);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R6 missing responses: got %0d pending expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule